// File: doc/BRIEF.md
# Dual-Channel DAC Register Front End

This block is the register-side control for a two-channel, 12-bit digital-to-analog converter. A 32-bit memory-mapped bus reaches five word registers. The control word holds a per-channel enable, a high-frequency mode select and two sticky lockout error flags. Each channel has a data-holding register, which takes 12-bit right-aligned unsigned codes. Each channel also has a read-only data-output register, which shows the code currently driven to the converter.

Each channel has its own enable, holding register, output register and output code bus toward the analog core. A disabled channel is reported powered down through its enable output, and its code stays frozen. In high-frequency mode, enabling a channel makes its holding register refuse writes for eight clock cycles. Each refused write is flagged in the control word.

Top module: `dual_dac_regs`

## Requirements
- R1: After reset, both channels are disabled, `code_o` is 0 and every register reads 0.
- R2: In the control word at offset 0x00, bit 0 enables channel 0, bit 16 enables channel 1 and bit 15 selects high-frequency mode. These bits read back as written, and `ch_en_o[c]` follows the enable of channel c one cycle after the write.
- R3: The holding registers are at 0x08 (channel 0) and 0x14 (channel 1). A write keeps only bits 11:0, and a read returns them zero-extended.
- R4: While a channel is enabled, its output code equals its holding value one clock later. The clock after an enable write, the held value is copied to the output.
- R5: While a channel is disabled, `ch_en_o[c]` is low (powered down) and its output code does not change, even when its holding register is written.
- R6: A 0-to-1 enable write made with bit 15 set in the same write blocks writes to that channel's holding register for the 8 following cycles. The write in the 9th cycle is accepted. When bit 15 is clear, no such window opens.
- R7: A blocked write leaves the holding register unchanged and sets a sticky error flag: bit 13 for channel 0, bit 29 for channel 1. Writing 1 to a flag clears it, and writing 0 to it has no effect.
- R8: The data-output registers at 0x2C (channel 0) and 0x30 (channel 1) read the applied code. Writes to them are ignored.
- R9: Addresses other than 0x00, 0x08, 0x14, 0x2C and 0x30 read as 0, and writes to them change nothing.
- R10: A lockout window on one channel does not block holding-register writes to the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address; bits 1:0 ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| ch_en_o | output | 2 | Channel enables; low means powered down |
| code_o | output | 24 | Output codes; channel 0 in 11:0, channel 1 in 23:12 |

## Verification
On every cycle, the assertions check four things: the output follows the held value one clock later while enabled, and stays frozen while disabled. A write during an active lockout leaves the holding register unchanged and raises the error flag. Unmapped addresses read zero. The exact length of the lockout window, the mode dependence of the window, the write-1-to-clear behaviour and the independence of the two channels are shown only by the bench's timed scenarios.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;
  localparam int DATA_W      = 32;
  localparam int CODE_W      = 12;
  localparam int NUM_CH      = 2;
  localparam int LOCK_CYCLES = 8;

  // control word layout
  localparam int CH_STRIDE = 16;
  localparam int EN_BIT    = 0;
  localparam int ERR_BIT   = 13;
  localparam int HF_BIT    = 15;

  // word indices (byte offset / 4)
  localparam int CTRL_WORD = 0;

  function automatic int hold_word(input int ch);
    return (ch == 0) ? 2 : 5;
  endfunction

  function automatic int out_word(input int ch);
    return (ch == 0) ? 11 : 12;
  endfunction
endpackage

// File: rtl/dac_lockout.sv
module dac_lockout #(
  parameter int LOCK_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (arm_i)             cnt_q <= CNT_W'(LOCK_CYCLES);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] hold_o,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] hold_q, code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (wr_i) hold_q <= wdata_i;
  end

  // output tracks holding register one clock behind while enabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= '0;
    else if (en_i) code_q <= hold_q;
  end

  assign hold_o = hold_q;
  assign code_o = code_q;
endmodule

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dac_regs_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] reject_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] err_o,
  output logic [NUM_CH-1:0] arm_o,
  output logic [DATA_W-1:0] ctrl_rd_o
);
  logic [NUM_CH-1:0] en_q, err_q;
  logic              hf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hf_q <= 1'b0;
    else if (wr_i) hf_q <= wdata_i[HF_BIT];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int EN_POS  = EN_BIT + c * CH_STRIDE;
    localparam int ERR_POS = ERR_BIT + c * CH_STRIDE;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q[c] <= 1'b0;
      else if (wr_i) en_q[c] <= wdata_i[EN_POS];
    end

    // set has priority over write-1-to-clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       err_q[c] <= 1'b0;
      else if (reject_i[c])              err_q[c] <= 1'b1;
      else if (wr_i && wdata_i[ERR_POS]) err_q[c] <= 1'b0;
    end

    assign arm_o[c] = wr_i && wdata_i[EN_POS] && !en_q[c] && wdata_i[HF_BIT];
  end

  always_comb begin
    ctrl_rd_o         = '0;
    ctrl_rd_o[HF_BIT] = hf_q;
    for (int c = 0; c < NUM_CH; c++) begin
      ctrl_rd_o[EN_BIT + c * CH_STRIDE]  = en_q[c];
      ctrl_rd_o[ERR_BIT + c * CH_STRIDE] = err_q[c];
    end
  end

  assign en_o  = en_q;
  assign err_o = err_q;
endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
  import dac_regs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_CH-1:0]          ch_en_o,
  output logic [NUM_CH*CODE_W-1:0]   code_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]             word;
  logic                          wr;
  logic                          ctrl_wr;
  logic [NUM_CH-1:0]             hit_hold, lock_act, arm, en, err, reject;
  logic [NUM_CH-1:0][CODE_W-1:0] hold_q, code_q;
  logic [DATA_W-1:0]             ctrl_rd;

  assign word    = addr_i[ADDR_W-1:2];
  assign wr      = req_i && we_i;
  assign ctrl_wr = wr && (int'(word) == CTRL_WORD);

  dac_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wdata_i   (wdata_i),
    .reject_i  (reject),
    .en_o      (en),
    .err_o     (err),
    .arm_o     (arm),
    .ctrl_rd_o (ctrl_rd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign hit_hold[c] = wr && (int'(word) == hold_word(c));
    assign reject[c]   = hit_hold[c] && lock_act[c];

    dac_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) i_lock (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (arm[c]),
      .active_o (lock_act[c])
    );

    dac_chan #(.CODE_W(CODE_W)) i_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en[c]),
      .wr_i    (hit_hold[c] && !lock_act[c]),
      .wdata_i (wdata_i[CODE_W-1:0]),
      .hold_o  (hold_q[c]),
      .code_o  (code_q[c])
    );

    assign code_o[c*CODE_W +: CODE_W] = code_q[c];
  end

  always_comb begin
    rdata_o = '0;
    if (int'(word) == CTRL_WORD) rdata_o = ctrl_rd;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(word) == hold_word(c)) rdata_o = DATA_W'(hold_q[c]);
      if (int'(word) == out_word(c))  rdata_o = DATA_W'(code_q[c]);
    end
  end

  assign ch_en_o = en;
endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk
  import dac_regs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [DATA_W-1:0]             rdata_o,
  input logic [NUM_CH-1:0]             ch_en_o,
  input logic [NUM_CH*CODE_W-1:0]      code_o,
  input logic [NUM_CH-1:0][CODE_W-1:0] hold_q,
  input logic [NUM_CH-1:0]             lock_act,
  input logic [NUM_CH-1:0]             hit_hold,
  input logic [NUM_CH-1:0]             err
);
  logic [7:0] w;
  logic       mapped;
  assign w      = 8'(addr_i >> 2);
  assign mapped = (w == 8'd0) || (w == 8'd2) || (w == 8'd5) ||
                  (w == 8'd11) || (w == 8'd12);

  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |-> (rdata_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r4_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_en_o[c] |=> (code_o[c*CODE_W +: CODE_W] == $past(hold_q[c])));

    a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en_o[c] |=> $stable(code_o[c*CODE_W +: CODE_W]));

    a_r6_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_act[c] |=> $stable(hold_q[c]));

    a_r7_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_act[c] && hit_hold[c]) |=> err[c]);
  end
endmodule

bind dual_dac_regs dual_dac_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .ch_en_o  (ch_en_o),
  .code_o   (code_o),
  .hold_q   (hold_q),
  .lock_act (lock_act),
  .hit_hold (hit_hold),
  .err      (err)
);

// File: tb/test_dual_dac_regs.sv
`timescale 1ns/1ps
module test_dual_dac_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ch_en;
  logic [23:0] code;

  int n_cmp = 0, n_bad = 0;

  localparam logic [9:0] A_CTRL = 10'h000, A_H0 = 10'h008, A_H1 = 10'h014,
                         A_O0 = 10'h02C, A_O1 = 10'h030;

  localparam int NV = 7;
  localparam logic        VEC_CH  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] VEC_WD  [NV] = '{32'h0000_0ABC, 32'hFFFF_F123, 32'h0000_0FFF,
                                           32'h0000_0000, 32'h0000_1000, 32'h0000_07FF,
                                           32'h0080_03C3};
  localparam logic [11:0] VEC_EXP [NV] = '{12'hABC, 12'h123, 12'hFFF, 12'h000,
                                           12'h000, 12'h7FF, 12'h3C3};

  always #2 clk = ~clk;

  dual_dac_regs i_dual_dac_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ch_en_o(ch_en), .code_o(code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one posedge per write
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #0.5;
    d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 code", {8'h0, code}, 32'h0);
    chk("R1 ch_en", {30'h0, ch_en}, 32'h0);
    rd_chk("R1 ctrl", A_CTRL, 32'h0);
    rd_chk("R1 hold0", A_H0, 32'h0);
    rd_chk("R1 out1", A_O1, 32'h0);

    // R2 enable both, no hf
    wr(A_CTRL, 32'h0001_0001);
    chk("R2 ch_en", {30'h0, ch_en}, 32'h3);
    rd_chk("R2 ctrl", A_CTRL, 32'h0001_0001);

    // R3/R4/R8 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [9:0] ha, oa;
      ha = VEC_CH[i] ? A_H1 : A_H0;
      oa = VEC_CH[i] ? A_O1 : A_O0;
      wr(ha, VEC_WD[i]);
      rd_chk("R3 hold", ha, {20'h0, VEC_EXP[i]});
      idle(1);
      chk("R4 code", {20'h0, VEC_CH[i] ? code[23:12] : code[11:0]}, {20'h0, VEC_EXP[i]});
      rd_chk("R8 out", oa, {20'h0, VEC_EXP[i]});
    end

    // R5 disable channel 0, write while off
    wr(A_CTRL, 32'h0001_0000);
    chk("R5 ch_en", {30'h0, ch_en}, 32'h2);
    wr(A_H0, 32'h0000_05A5);
    idle(2);
    chk("R5 frozen", {20'h0, code[11:0]}, 32'h3C3);
    rd_chk("R5 hold", A_H0, 32'h5A5);
    // R4 enable copies on next clock
    wr(A_CTRL, 32'h0001_0001);
    chk("R4 pre-copy", {20'h0, code[11:0]}, 32'h3C3);
    idle(1);
    chk("R4 copy", {20'h0, code[11:0]}, 32'h5A5);

    // R8 writes to output registers ignored
    wr(A_O0, 32'h0000_0FFF);
    idle(1);
    rd_chk("R8 out ro", A_O0, 32'h5A5);
    chk("R8 code ro", {20'h0, code[11:0]}, 32'h5A5);

    // R9 unmapped
    wr(10'h004, 32'hFFFF_FFFF);
    wr(10'h3FC, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped 04", 10'h004, 32'h0);
    rd_chk("R9 unmapped 3fc", 10'h3FC, 32'h0);
    rd_chk("R9 ctrl intact", A_CTRL, 32'h0001_0001);

    // R6/R10 lockout on channel 0
    wr(A_CTRL, 32'h0001_0000);
    wr(A_CTRL, 32'h0001_8001);          // edge E
    wr(A_H0, 32'h0000_0111);            // E+1 blocked
    wr(A_H1, 32'h0000_0777);            // E+2 other channel
    rd_chk("R10 other chan", A_H1, 32'h777);
    idle(5);                            // E+3..E+7
    wr(A_H0, 32'h0000_0222);            // E+8 blocked
    rd_chk("R6 blocked", A_H0, 32'h5A5);
    rd_chk("R7 err0 set", A_CTRL, 32'h0001_A001);
    wr(A_H0, 32'h0000_0333);            // E+9 accepted
    rd_chk("R6 after window", A_H0, 32'h333);
    idle(1);
    chk("R4 code after window", {20'h0, code[11:0]}, 32'h333);

    // R7 sticky, write-1-to-clear
    wr(A_CTRL, 32'h0001_8001);
    rd_chk("R7 sticky", A_CTRL, 32'h0001_A001);
    wr(A_CTRL, 32'h0001_A001);
    rd_chk("R7 cleared", A_CTRL, 32'h0001_8001);

    // R6 no window without hf
    wr(A_CTRL, 32'h0001_0000);
    wr(A_CTRL, 32'h0001_0001);
    wr(A_H0, 32'h0000_0444);
    rd_chk("R6 no hf", A_H0, 32'h444);

    // R6/R7 lockout on channel 1
    wr(A_CTRL, 32'h0000_8001);
    wr(A_CTRL, 32'h0001_8001);
    wr(A_H1, 32'h0000_0888);
    rd_chk("R6 ch1 blocked", A_H1, 32'h777);
    rd_chk("R7 err1 set", A_CTRL, 32'h2001_8001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule